// File: doc/BRIEF.md
# USB Transfer Descriptor Executor

This block carries out one transfer descriptor of a USB host controller. The caller fetches the descriptor from memory. It then hands over the descriptor's 32-bit control/status word and its 32-bit token word with a one-cycle start pulse. The block decodes the token into a packet identifier, device address, endpoint and maximum length. It then raises a transaction request toward a bus-transaction stub and holds it until that stub answers.

The answer is one of five kinds: data moved with a byte count, NAK, stall, error or pending. From it the block rewrites the control/status word in place. For one cycle it presents that word, a two-bit return code and a three-bit interrupt-cause mask, marked by a done pulse. The caller writes the word back to the descriptor and uses the return code to decide how the queue walk goes on. A descriptor that is not active is answered at once, with no transaction.

Top module: `td_executor`

## Requirements
- R1: While `xact_req_o` is high, `xact_pid_o` equals token bits [7:0], `xact_dev_o` equals token bits [14:8] and `xact_ep_o` equals token bits [18:15].
- R2: `xact_maxlen_o` equals (token[31:21] + 1) modulo 2048, so an all-ones field gives 0.
- R3: `irq_mask_o` bit 0 equals the interrupt-on-complete bit (control bit 24) on every done pulse, whether or not the descriptor was active.
- R4: When the active bit (control bit 23) is clear, no request is raised. `done_o` pulses one cycle after start, with return code 1 (skip) and the control word unchanged.
- R5: A data response (kind 0) replaces control bits [10:0] with (byte count − 1) modulo 2048. It clears the active bit and the NAK bit (control bit 19) and returns code 0 (success).
- R6: `irq_mask_o` bit 1 is set only when a data response has PID 0x69 (IN), short-packet-detect (control bit 29) is set and the byte count is below the maximum length.
- R7: An error response (kind 3 or any code above 4) returns code 1. A nonzero error count in control bits [28:27] is decremented. If that takes it to zero, the active bit is cleared, the stalled bit (control bit 22) is set and `irq_mask_o` bit 2 is raised. A zero count stays zero and the descriptor stays active.
- R8: A pending response (kind 4) returns code 3 and leaves the control word unchanged, active included.
- R9: A NAK response (kind 1) sets the NAK bit, keeps the descriptor active and returns code 2 (frame abort).
- R10: A stall response (kind 2) clears the active bit, sets the stalled bit and returns code 1.
- R11: `xact_req_o` is high from the cycle after an active start until the cycle in which `rsp_valid_i` is seen. `done_o` is high for exactly the following cycle, and a start pulse while busy is ignored.
- R12: After reset, `done_o`, `xact_req_o` and `busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin evaluating a descriptor |
| ctrl_i | input | 32 | Control/status word of the descriptor |
| token_i | input | 32 | Token word of the descriptor |
| busy_o | output | 1 | A transaction is outstanding |
| xact_req_o | output | 1 | Transaction request to the bus stub |
| xact_pid_o | output | 8 | Packet identifier |
| xact_dev_o | output | 7 | Device address |
| xact_ep_o | output | 4 | Endpoint number |
| xact_maxlen_o | output | 11 | Maximum transfer length in bytes |
| rsp_valid_i | input | 1 | Response from the bus stub is valid |
| rsp_kind_i | input | 3 | 0 data, 1 NAK, 2 stall, 3 error, 4 pending |
| rsp_len_i | input | 11 | Bytes moved for a data response |
| done_o | output | 1 | One-cycle result strobe |
| ctrl_o | output | 32 | Rewritten control/status word |
| rc_o | output | 2 | 0 success, 1 skip/failed, 2 frame abort, 3 pending |
| irq_mask_o | output | 3 | Bit 0 completion, bit 1 short packet, bit 2 error limit |

## Verification
A sequencer stuck in its waiting state shows up as `busy_o` and `xact_req_o` staying high after a response, visible in the next cycle. A stale or corrupted captured descriptor shows up in the very next done pulse: the control word comes out wrong, or the completion bit of the mask disagrees with the word that was started. Errors in the status rewrite, such as an off-by-one length, a kept NAK bit or a wrong count decrement, show up in `ctrl_o` on the done cycle of the descriptor that hits that case.

// File: rtl/td_pkg.sv
package td_pkg;

    localparam int CW_W   = 32;
    localparam int LEN_W  = 11;
    localparam int PID_W  = 8;
    localparam int DEV_W  = 7;
    localparam int EP_W   = 4;
    localparam int ERR_W  = 2;
    localparam int MASK_W = 3;

    // control/status bit positions
    localparam int B_NAK   = 19;
    localparam int B_STALL = 22;
    localparam int B_ACT   = 23;
    localparam int B_IOC   = 24;
    localparam int B_ERRLO = 27;
    localparam int B_SPD   = 29;

    // token field positions
    localparam int T_DEV = 8;
    localparam int T_EP  = 15;
    localparam int T_LEN = 21;

    localparam logic [PID_W-1:0] PID_IN = 8'h69;

    typedef enum logic [2:0] {
        RSP_DATA  = 3'd0,
        RSP_NAK   = 3'd1,
        RSP_STALL = 3'd2,
        RSP_ERROR = 3'd3,
        RSP_PEND  = 3'd4
    } rsp_kind_e;

    typedef enum logic [1:0] {
        RC_OK    = 2'd0,
        RC_SKIP  = 2'd1,
        RC_ABORT = 2'd2,
        RC_PEND  = 2'd3
    } td_rc_e;

    typedef struct packed {
        logic [PID_W-1:0] pid;
        logic [DEV_W-1:0] dev;
        logic [EP_W-1:0]  ep;
        logic [LEN_W-1:0] maxlen;
    } td_tok_t;

    typedef struct packed {
        logic [CW_W-1:0]   ctrl;
        td_rc_e            rc;
        logic [MASK_W-1:0] mask;
    } td_res_t;

    function automatic logic [LEN_W-1:0] wrap_inc(input logic [LEN_W-1:0] v);
        return v + LEN_W'(1);
    endfunction

    function automatic logic [LEN_W-1:0] wrap_dec(input logic [LEN_W-1:0] v);
        return v - LEN_W'(1);
    endfunction

endpackage

// File: rtl/td_token_decode.sv
module td_token_decode
    import td_pkg::*;
(
    input  logic [CW_W-1:0] token_i,
    output td_tok_t         tok_o
);
    logic [1:0] unused_tok;

    always_comb begin
        tok_o.pid    = token_i[PID_W-1:0];
        tok_o.dev    = token_i[T_DEV +: DEV_W];
        tok_o.ep     = token_i[T_EP +: EP_W];
        tok_o.maxlen = wrap_inc(token_i[T_LEN +: LEN_W]);
    end

    assign unused_tok = token_i[T_LEN-1:T_EP+EP_W];
endmodule

// File: rtl/td_status_update.sv
module td_status_update
    import td_pkg::*;
(
    input  logic [CW_W-1:0]  ctrl_i,
    input  td_tok_t          tok_i,
    input  logic [2:0]       kind_i,
    input  logic [LEN_W-1:0] len_i,
    output td_res_t          res_o
);
    logic [ERR_W-1:0] err_cur;
    logic [ERR_W-1:0] err_nxt;
    logic             is_short;

    assign err_cur  = ctrl_i[B_ERRLO +: ERR_W];
    assign err_nxt  = (err_cur == '0) ? '0 : err_cur - ERR_W'(1);
    assign is_short = (tok_i.pid == PID_IN) && ctrl_i[B_SPD] && (len_i < tok_i.maxlen);

    always_comb begin
        res_o.ctrl    = ctrl_i;
        res_o.rc      = RC_SKIP;
        res_o.mask    = '0;
        res_o.mask[0] = ctrl_i[B_IOC];
        if (ctrl_i[B_ACT]) begin
            case (kind_i)
                RSP_DATA: begin
                    res_o.ctrl[LEN_W-1:0] = wrap_dec(len_i);
                    res_o.ctrl[B_ACT]     = 1'b0;
                    res_o.ctrl[B_NAK]     = 1'b0;
                    res_o.rc              = RC_OK;
                    res_o.mask[1]         = is_short;
                end
                RSP_NAK: begin
                    res_o.ctrl[B_NAK] = 1'b1;
                    res_o.rc          = RC_ABORT;
                end
                RSP_STALL: begin
                    res_o.ctrl[B_ACT]   = 1'b0;
                    res_o.ctrl[B_STALL] = 1'b1;
                end
                RSP_PEND: begin
                    res_o.rc = RC_PEND;
                end
                default: begin
                    res_o.ctrl[B_ERRLO +: ERR_W] = err_nxt;
                    if (err_cur == ERR_W'(1)) begin
                        res_o.ctrl[B_ACT]   = 1'b0;
                        res_o.ctrl[B_STALL] = 1'b1;
                        res_o.mask[2]       = 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/td_seq.sv
module td_seq (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic active_i,
    input  logic rsp_valid_i,
    output logic busy_o,
    output logic capture_o,
    output logic finish_o
);
    typedef enum logic {S_IDLE, S_WAIT} seq_st_e;
    seq_st_e st_q;

    assign busy_o    = (st_q == S_WAIT);
    assign capture_o = (st_q == S_IDLE) && start_i;
    assign finish_o  = (capture_o && !active_i) || (busy_o && rsp_valid_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= S_IDLE;
        end else begin
            case (st_q)
                S_IDLE: if (start_i && active_i) st_q <= S_WAIT;
                S_WAIT: if (rsp_valid_i) st_q <= S_IDLE;
                default: st_q <= S_IDLE;
            endcase
        end
    end

    // R11
    wait_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && rsp_valid_i) |=> !busy_o);
    // R11
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !rsp_valid_i) |=> busy_o);
endmodule

// File: rtl/td_executor.sv
module td_executor
    import td_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [CW_W-1:0]   ctrl_i,
    input  logic [CW_W-1:0]   token_i,
    output logic              busy_o,
    output logic              xact_req_o,
    output logic [PID_W-1:0]  xact_pid_o,
    output logic [DEV_W-1:0]  xact_dev_o,
    output logic [EP_W-1:0]   xact_ep_o,
    output logic [LEN_W-1:0]  xact_maxlen_o,
    input  logic              rsp_valid_i,
    input  logic [2:0]        rsp_kind_i,
    input  logic [LEN_W-1:0]  rsp_len_i,
    output logic              done_o,
    output logic [CW_W-1:0]   ctrl_o,
    output logic [1:0]        rc_o,
    output logic [MASK_W-1:0] irq_mask_o
);
    logic            busy, capture, finish;
    logic [CW_W-1:0] cur_ctrl, cur_tok, src_ctrl, src_tok;
    td_tok_t         tok;
    td_res_t         res, res_q;
    logic            done_q;

    td_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .active_i    (ctrl_i[B_ACT]),
        .rsp_valid_i (rsp_valid_i),
        .busy_o      (busy),
        .capture_o   (capture),
        .finish_o    (finish)
    );

    assign src_ctrl = busy ? cur_ctrl : ctrl_i;
    assign src_tok  = busy ? cur_tok  : token_i;

    td_token_decode u_dec (
        .token_i (src_tok),
        .tok_o   (tok)
    );

    td_status_update u_upd (
        .ctrl_i (src_ctrl),
        .tok_i  (tok),
        .kind_i (rsp_kind_i),
        .len_i  (rsp_len_i),
        .res_o  (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_ctrl <= '0;
            cur_tok  <= '0;
            done_q   <= 1'b0;
            res_q    <= '0;
        end else begin
            done_q <= finish;
            if (capture) begin
                cur_ctrl <= ctrl_i;
                cur_tok  <= token_i;
            end
            if (finish) res_q <= res;
        end
    end

    assign busy_o        = busy;
    assign xact_req_o    = busy;
    assign xact_pid_o    = tok.pid;
    assign xact_dev_o    = tok.dev;
    assign xact_ep_o     = tok.ep;
    assign xact_maxlen_o = tok.maxlen;
    assign done_o        = done_q;
    assign ctrl_o        = res_q.ctrl;
    assign rc_o          = res_q.rc;
    assign irq_mask_o    = res_q.mask;

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    // R11
    rsp_to_done_chk: assert property (@(posedge clk) disable iff (rst)
        (xact_req_o && rsp_valid_i) |=> (done_o && !xact_req_o));
    // R3
    ioc_mask_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (irq_mask_o[0] == cur_ctrl[B_IOC]));
    // R4
    inactive_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !cur_ctrl[B_ACT]) |-> (rc_o == RC_SKIP && ctrl_o == cur_ctrl));
    // R5
    ok_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && rc_o == RC_OK) |-> (!ctrl_o[B_ACT] && !ctrl_o[B_NAK]));
    // R8
    pend_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && rc_o == RC_PEND) |-> (ctrl_o == cur_ctrl));
    // R9
    abort_nak_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && rc_o == RC_ABORT) |-> (ctrl_o[B_NAK] && ctrl_o[B_ACT]));
    // R6
    short_in_only_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && irq_mask_o[1]) |-> (rc_o == RC_OK && cur_tok[7:0] == PID_IN));
endmodule

// File: tb/tb_td_executor.sv
module tb_td_executor;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] ctrl_i = '0;
    logic [31:0] token_i = '0;
    logic        busy_o, xact_req_o, done_o;
    logic [7:0]  xact_pid_o;
    logic [6:0]  xact_dev_o;
    logic [3:0]  xact_ep_o;
    logic [10:0] xact_maxlen_o;
    logic        rsp_valid_i = 1'b0;
    logic [2:0]  rsp_kind_i = '0;
    logic [10:0] rsp_len_i = '0;
    logic [31:0] ctrl_o;
    logic [1:0]  rc_o;
    logic [2:0]  irq_mask_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit ended = 0;

    localparam logic [31:0] ACT = 32'h0080_0000;
    localparam logic [31:0] IOC = 32'h0100_0000;
    localparam logic [31:0] SPD = 32'h2000_0000;
    localparam logic [31:0] NAK = 32'h0008_0000;
    localparam logic [31:0] STL = 32'h0040_0000;
    localparam logic [31:0] E1  = 32'h0800_0000;
    localparam logic [31:0] E2  = 32'h1000_0000;
    localparam logic [31:0] E3  = 32'h1800_0000;
    // IN, device 5, endpoint 2, max length 64
    localparam logic [31:0] TOK_IN  = 32'h07E1_0569;
    localparam logic [31:0] TOK_OUT = 32'h07E1_05E1;

    always #10 clk = ~clk;

    td_executor dut (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !ended) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            summary();
        end
    end

    // runs one descriptor; kind 7 = no transaction expected
    task automatic run_td(input string req, input logic [31:0] c, input logic [31:0] t,
                          input logic [2:0] kind, input logic [10:0] len, input int dly,
                          input logic [31:0] e_ctrl, input logic [1:0] e_rc, input logic [2:0] e_mask);
        @(negedge clk);
        start_i = 1; ctrl_i = c; token_i = t;
        @(negedge clk);
        start_i = 0;
        if (kind != 3'd7) begin
            chk(xact_req_o === 1'b1, {req, " R11 req"}, 32'(xact_req_o), 1);
            repeat (dly) @(negedge clk);
            rsp_valid_i = 1; rsp_kind_i = kind; rsp_len_i = len;
            @(negedge clk);
            rsp_valid_i = 0;
        end else begin
            chk(xact_req_o === 1'b0, {req, " R4 no req"}, 32'(xact_req_o), 0);
        end
        chk(done_o === 1'b1, {req, " done"}, 32'(done_o), 1);
        chk(ctrl_o === e_ctrl, {req, " ctrl"}, ctrl_o, e_ctrl);
        chk(rc_o === e_rc, {req, " rc"}, 32'(rc_o), 32'(e_rc));
        chk(irq_mask_o === e_mask, {req, " R3 mask"}, 32'(irq_mask_o), 32'(e_mask));
        @(negedge clk);
        chk(done_o === 1'b0, {req, " R11 done once"}, 32'(done_o), 0);
    endtask

    task automatic t_reset();
        chk(done_o === 0 && xact_req_o === 0 && busy_o === 0, "R12 reset",
            {29'd0, done_o, xact_req_o, busy_o}, 0);
    endtask

    task automatic t_decode();
        @(negedge clk);
        start_i = 1; ctrl_i = ACT; token_i = 32'hFFE9_8A2D; // dev 0x0A, ep 3, maxlen 0
        @(negedge clk);
        start_i = 0;
        chk(xact_pid_o === 8'h2D, "R1 pid", 32'(xact_pid_o), 32'h2D);
        chk(xact_dev_o === 7'h0A, "R1 dev", 32'(xact_dev_o), 32'h0A);
        chk(xact_ep_o === 4'h3, "R1 ep", 32'(xact_ep_o), 3);
        chk(xact_maxlen_o === 11'd0, "R2 maxlen wrap", 32'(xact_maxlen_o), 0);
        rsp_valid_i = 1; rsp_kind_i = 3'd0; rsp_len_i = 11'd0;
        @(negedge clk);
        rsp_valid_i = 0;
        chk(ctrl_o === 32'h0000_07FF, "R5 zero length", ctrl_o, 32'h0000_07FF);
        @(negedge clk);
        run_td("R2 maxlen 64", ACT, TOK_IN, 3'd0, 11'd64, 0, 32'h0000_003F, 2'd0, 3'b000);
    endtask

    task automatic t_busy();
        @(negedge clk);
        start_i = 1; ctrl_i = ACT | IOC; token_i = TOK_OUT;
        @(negedge clk);
        ctrl_i = 32'h0; token_i = 32'h0; // second start while busy
        @(negedge clk);
        start_i = 0;
        chk(busy_o === 1'b1 && xact_pid_o === 8'hE1, "R11 busy start ignored",
            32'(xact_pid_o), 32'hE1);
        repeat (3) @(negedge clk);
        chk(xact_req_o === 1'b1, "R11 req held", 32'(xact_req_o), 1);
        rsp_valid_i = 1; rsp_kind_i = 3'd0; rsp_len_i = 11'd5;
        @(negedge clk);
        rsp_valid_i = 0;
        chk(done_o === 1 && ctrl_o === (IOC | 32'h4), "R11 first descriptor result",
            ctrl_o, IOC | 32'h4);
        chk(xact_req_o === 1'b0, "R11 req dropped", 32'(xact_req_o), 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        run_td("R4 inactive", IOC | 32'h123, TOK_IN, 3'd7, 0, 0, IOC | 32'h123, 2'd1, 3'b001);
        t_decode();
        run_td("R5 full IN", ACT | SPD | NAK | 32'h7FF, TOK_IN, 3'd0, 11'd64, 1,
               SPD | 32'h3F, 2'd0, 3'b000);
        run_td("R6 short IN", ACT | SPD | IOC, TOK_IN, 3'd0, 11'd10, 2,
               SPD | IOC | 32'h9, 2'd0, 3'b011);
        run_td("R6 short OUT", ACT | SPD, TOK_OUT, 3'd0, 11'd10, 0, SPD | 32'h9, 2'd0, 3'b000);
        run_td("R6 IN no SPD", ACT, TOK_IN, 3'd0, 11'd10, 0, 32'h9, 2'd0, 3'b000);
        run_td("R9 nak", ACT | E3, TOK_IN, 3'd1, 0, 0, ACT | NAK | E3, 2'd2, 3'b000);
        run_td("R10 stall", ACT | 32'h7FF, TOK_IN, 3'd2, 0, 0, STL | 32'h7FF, 2'd1, 3'b000);
        run_td("R7 err 3", ACT | E3, TOK_IN, 3'd3, 0, 0, ACT | E2, 2'd1, 3'b000);
        run_td("R7 err 1", ACT | E1, TOK_IN, 3'd3, 0, 0, STL, 2'd1, 3'b100);
        run_td("R7 err 0", ACT, TOK_IN, 3'd6, 0, 0, ACT, 2'd1, 3'b000);
        run_td("R8 pending", ACT | IOC, TOK_IN, 3'd4, 0, 4, ACT | IOC, 2'd3, 3'b001);
        t_busy();
        summary();
    end
endmodule